// File: doc/BRIEF.md
# Eight-bit compare-match timer channel

This block is one 8-bit timer channel. An up-counter advances once on each cycle where the external step input is high, so the prescaler stays outside the block. Two compare registers are matched against the counter. A match, or a wrap of the counter from all ones to zero, sets a sticky flag in a control/status register. Each flag is also driven as a level interrupt request. Each compare match applies a programmable 2-bit action to one timer output pin. Compare match A can also raise a one-cycle start request for an A/D converter.

Software reaches the block over a simple synchronous bus with read and write strobes. A flag clears only when software writes 0 to it after a status read that returned it as 1. A transfer controller can also clear a flag with a per-flag acknowledge, gated by a clear-enable input. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `tmr8_chan`

## Requirements
- R1: After reset the status register reads 0x00, both compare registers read 0xFF, the counter reads 0x00, and the timer output, the A/D request and all interrupt requests are 0.
- R2: The counter advances by one at each clock edge where step is 1. A bus write to the counter loads it; in that cycle the advance is suppressed and no match or wrap event occurs.
- R3: At a clock edge where step is 1 and the counter equals compare register A, status bit 6 (and irq_cmpa) becomes 1. The same holds for compare register B, with status bit 7 and irq_cmpb. Each flag's interrupt output follows its flag level.
- R4: At a clock edge where step is 1 and the counter is 0xFF, the counter becomes 0x00 and status bit 5 (and irq_wrap) becomes 1.
- R5: Writing 1 to status bits 7, 6 or 5 never changes them.
- R6: Writing 0 to a flag bit clears it only if the last status read since the previous status write returned that bit as 1. Every status write consumes this armed state.
- R7: A flag clears when its ack bit is 1 while ack_clr_en is 1. With ack_clr_en at 0, ack has no effect.
- R8: When a set event and a clear (by write or ack) hit the same flag in the same cycle, the flag ends up 1.
- R9: Status bits [1:0] choose the action on compare match A and bits [3:2] choose it on compare match B. The encodings are 00 no change, 01 drive 0, 10 drive 1, 11 toggle. The output changes at the edge of the match.
- R10: When both matches occur in one cycle, toggle wins over drive 1, which wins over drive 0. An action of 00 defers to the other match's action.
- R11: When status bit 4 is 1, each compare match A makes adc_start high for exactly one cycle, starting at the edge where the flag sets. When bit 4 is 0, adc_start stays 0.
- R12: With HAS_ADC=0, status bit 4 always reads 1 and writes to it are ignored.
- R13: Bus addresses are 0 status, 1 compare A, 2 compare B, 3 counter. Read data appears on bus_rdata in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Counter advance enable from the prescaler |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ack | input | 3 | Transfer-controller acknowledge per flag: [2] match B, [1] match A, [0] wrap |
| ack_clr_en | input | 1 | Allows ack to clear flags |
| irq_cmpb | output | 1 | Match B flag level |
| irq_cmpa | output | 1 | Match A flag level |
| irq_wrap | output | 1 | Wrap flag level |
| tmr_out | output | 1 | Timer output pin |
| adc_start | output | 1 | One-cycle A/D start request |

## Verification
The bench targets the read-before-clear handshake from several directions. It writes 0 with no prior read, writes 1 after a read, and clears one flag while a second flag was set only after the read. A design that cleared on any 0 write, or that armed every flag on a read, would drop a flag that should survive. It also runs a set and a clear in the same cycle, where a clear-wins design would lose an event. Walking every action pairing through a simultaneous match catches a wrong priority order. Loading the counter with a match value while step is high catches a design that takes a spurious match during the load.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  localparam int AW        = 2;
  localparam int NFLAGS    = 3;
  localparam int FLG_WRAP  = 0;
  localparam int FLG_CMPA  = 1;
  localparam int FLG_CMPB  = 2;
  localparam int FLAG_LSB  = 5;
  localparam int ADE_BIT   = 4;

  localparam logic [AW-1:0] A_CSR  = 2'd0;
  localparam logic [AW-1:0] A_CMPA = 2'd1;
  localparam logic [AW-1:0] A_CMPB = 2'd2;
  localparam logic [AW-1:0] A_CNT  = 2'd3;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] cnt,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  logic adv;
  assign adv   = step && !load;
  assign hit_a = adv && (cnt == cmp_a);
  assign hit_b = adv && (cnt == cmp_b);
  assign wrap  = adv && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R2
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_csr,
  input  logic wr_csr,
  input  logic wbit,
  input  logic ack,
  input  logic ack_en,
  output logic flag
);
  logic armed_q;
  logic clr;

  assign clr = (wr_csr && armed_q && !wbit) || (ack && ack_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_ev)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (wr_csr)      armed_q <= 1'b0;
      else if (rd_csr) armed_q <= flag;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag); // R8
  AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_csr && !armed_q && !(ack && ack_en)) |=> flag); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_en && !set_ev) |=> !flag); // R7
endmodule

// File: rtl/tmr8_outctl.sv
module tmr8_outctl
  import tmr8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_a,
  input  logic hit_b,
  input  act_e act_a,
  input  act_e act_b,
  output logic pin
);
  logic any_tog, any_hi, any_lo, pin_d;

  always_comb begin
    any_tog = (hit_a && act_a == ACT_TOGGLE) || (hit_b && act_b == ACT_TOGGLE);
    any_hi  = (hit_a && act_a == ACT_HIGH)   || (hit_b && act_b == ACT_HIGH);
    any_lo  = (hit_a && act_a == ACT_LOW)    || (hit_b && act_b == ACT_LOW);
    if (any_tog)     pin_d = !pin;
    else if (any_hi) pin_d = 1'b1;
    else if (any_lo) pin_d = 1'b0;
    else             pin_d = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a || hit_b) |=> $stable(pin)); // R9
  AST_TOGGLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && hit_b && act_a == ACT_TOGGLE) |=> (pin != $past(pin))); // R10
endmodule

// File: rtl/tmr8_chan.sv
module tmr8_chan
  import tmr8_pkg::*;
#(
  parameter int W       = 8,
  parameter bit HAS_ADC = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [1:0]   bus_addr,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [2:0]   ack,
  input  logic         ack_clr_en,
  output logic         irq_cmpb,
  output logic         irq_cmpa,
  output logic         irq_wrap,
  output logic         tmr_out,
  output logic         adc_start
);
  localparam logic [W-1:0] CMP_RST = '1;

  logic [W-1:0]        cmp_a_q, cmp_b_q, cnt;
  logic [3:0]          os_q;
  logic                ade;
  logic                hit_a, hit_b, wrap;
  logic                csr_wr, csr_rd, cnt_ld;
  logic [NFLAGS-1:0]   set_vec, flags;
  logic [7:0]          csr_view;

  assign csr_wr = bus_wr && (bus_addr == A_CSR);
  assign csr_rd = bus_rd && (bus_addr == A_CSR);
  assign cnt_ld = bus_wr && (bus_addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= CMP_RST;
      cmp_b_q <= CMP_RST;
      os_q    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CSR:   os_q    <= bus_wdata[3:0];
        A_CMPA:  cmp_a_q <= bus_wdata;
        A_CMPB:  cmp_b_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_ADC) begin : g_adc
      logic ade_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ade_q     <= 1'b0;
          adc_start <= 1'b0;
        end else begin
          if (csr_wr) ade_q <= bus_wdata[ADE_BIT];
          adc_start <= hit_a && ade_q;
        end
      end
      assign ade = ade_q;
      AST_ADC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R11
    end else begin : g_no_adc
      assign ade       = 1'b0;
      assign adc_start = 1'b0;
    end
  endgenerate

  tmr8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_ld),
    .load_val(bus_wdata), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q),
    .cnt(cnt), .hit_a(hit_a), .hit_b(hit_b), .wrap(wrap)
  );

  assign set_vec[FLG_WRAP] = wrap;
  assign set_vec[FLG_CMPA] = hit_a;
  assign set_vec[FLG_CMPB] = hit_b;

  generate
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      tmr8_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_ev(set_vec[i]),
        .rd_csr(csr_rd), .wr_csr(csr_wr), .wbit(bus_wdata[FLAG_LSB+i]),
        .ack(ack[i]), .ack_en(ack_clr_en), .flag(flags[i])
      );
    end
  endgenerate

  tmr8_outctl u_out (
    .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
    .act_a(act_e'(os_q[1:0])), .act_b(act_e'(os_q[3:2])), .pin(tmr_out)
  );

  assign csr_view = {flags, (HAS_ADC ? ade : 1'b1), os_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CSR:   bus_rdata <= W'(csr_view);
        A_CMPA:  bus_rdata <= cmp_a_q;
        A_CMPB:  bus_rdata <= cmp_b_q;
        default: bus_rdata <= cnt;
      endcase
    end
  end

  assign irq_cmpb = flags[FLG_CMPB];
  assign irq_cmpa = flags[FLG_CMPA];
  assign irq_wrap = flags[FLG_WRAP];

  AST_ONE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && (bus_wdata[7:5] == 3'b111) && !(|(ack & {3{ack_clr_en}})))
      |=> (flags == $past(flags) | $past(set_vec))); // R5
  AST_CMPA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> irq_cmpa); // R3
endmodule

// File: tb/tmr8_chan_tb.sv
module tmr8_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, rdata2;
  logic [2:0] ack = '0;
  logic       ack_clr_en = 1'b0;
  logic       irq_cmpb, irq_cmpa, irq_wrap, tmr_out, adc_start;
  logic       n_cb, n_ca, n_wr, n_out, n_adc;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tmr8_chan dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack(ack), .ack_clr_en(ack_clr_en),
    .irq_cmpb(irq_cmpb), .irq_cmpa(irq_cmpa), .irq_wrap(irq_wrap),
    .tmr_out(tmr_out), .adc_start(adc_start)
  );

  tmr8_chan #(.HAS_ADC(1'b0)) dut_noadc (
    .clk(clk), .rst_n(rst_n), .step(step), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata2), .ack(ack), .ack_clr_en(ack_clr_en),
    .irq_cmpb(n_cb), .irq_cmpa(n_ca), .irq_wrap(n_wr),
    .tmr_out(n_out), .adc_start(n_adc)
  );

  // {os[3:0] = {act_b, act_a}, cmp_a, cmp_b, start count, expected tmr_out}
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {4'b0010, 8'd5, 8'd9, 8'd5, 1'b1},
    {4'b0100, 8'd5, 8'd9, 8'd9, 1'b0},
    {4'b0011, 8'd5, 8'd9, 8'd5, 1'b1},
    {4'b1111, 8'd7, 8'd7, 8'd7, 1'b0},
    {4'b1001, 8'd7, 8'd7, 8'd7, 1'b1},
    {4'b0111, 8'd7, 8'd7, 8'd7, 1'b0},
    {4'b1110, 8'd7, 8'd7, 8'd7, 1'b1},
    {4'b0001, 8'd7, 8'd7, 8'd7, 1'b0},
    {4'b1010, 8'd7, 8'd7, 8'd8, 1'b0},
    {4'b1000, 8'd7, 8'd7, 8'd7, 1'b1},
    {4'b0000, 8'd7, 8'd7, 8'd7, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 csr", d, 8'h00);
    chk("R12 bit4 reads 1", rdata2, 8'h10);
    rd(2'd1, d); chk("R1 cmp_a", d, 8'hFF);
    rd(2'd2, d); chk("R13 cmp_b", d, 8'hFF);
    rd(2'd3, d); chk("R1 counter", d, 8'h00);
    chk("R1 outputs", {3'b0, tmr_out, adc_start, irq_cmpb, irq_cmpa, irq_wrap}, 8'h00);

    // R9 R10 action table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {3'b111, 1'b0, VEC[i][28:25]});
      wr(2'd1, VEC[i][24:17]);
      wr(2'd2, VEC[i][16:9]);
      wr(2'd3, VEC[i][8:1]);
      pulse_step();
      chk($sformatf("R9/R10 vector %0d tmr_out", i), {7'b0, tmr_out}, {7'b0, VEC[i][0]});
    end

    do_reset();
    // R3 match A sets flag; R2 counter advance
    wr(2'd1, 8'd3); wr(2'd3, 8'd3); pulse_step();
    chk("R3 irq_cmpa/irq_cmpb", {6'b0, irq_cmpb, irq_cmpa}, 8'h01);
    rd(2'd0, d); chk("R3 csr bit6", d, 8'h40);
    rd(2'd3, d); chk("R2 counter advanced", d, 8'd4);
    // R5 writing 1 after a read leaves flag
    wr(2'd0, 8'hE0); chk("R5 written 1 no effect", {7'b0, irq_cmpa}, 8'h01);
    // R6 0 write without read
    wr(2'd0, 8'h00); chk("R6 blind 0 write", {7'b0, irq_cmpa}, 8'h01);
    rd(2'd0, d); wr(2'd0, 8'h00); chk("R6 read then 0 clears", {7'b0, irq_cmpa}, 8'h00);
    // R6 only flags seen by the read clear
    wr(2'd3, 8'd3); pulse_step();
    rd(2'd0, d);
    wr(2'd2, 8'd9); wr(2'd3, 8'd9); pulse_step();
    wr(2'd0, 8'h00);
    chk("R6 selective clear", {6'b0, irq_cmpb, irq_cmpa}, 8'h02);
    // R7 ack
    @(negedge clk); ack = 3'b100; ack_clr_en = 1'b0;
    @(negedge clk); ack = 3'b000;
    chk("R7 ack without enable", {7'b0, irq_cmpb}, 8'h01);
    @(negedge clk); ack = 3'b100; ack_clr_en = 1'b1;
    @(negedge clk); ack = 3'b000; ack_clr_en = 1'b0;
    chk("R7 ack with enable", {7'b0, irq_cmpb}, 8'h00);
    // R8 set beats clear
    wr(2'd3, 8'd3); pulse_step();
    wr(2'd3, 8'd3); rd(2'd0, d);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1; step = 1'b1;
    @(negedge clk); bus_wr = 1'b0; step = 1'b0;
    chk("R8 set wins", {7'b0, irq_cmpa}, 8'h01);
    // R4 wrap
    wr(2'd3, 8'hFF); pulse_step();
    chk("R4 irq_wrap", {7'b0, irq_wrap}, 8'h01);
    rd(2'd3, d); chk("R4 counter wrapped", d, 8'h00);
    // R11 A/D pulse
    wr(2'd0, 8'h10); wr(2'd1, 8'd20); wr(2'd3, 8'd20);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R11 adc_start high", {7'b0, adc_start}, 8'h01);
    @(negedge clk);
    chk("R11 adc_start one cycle", {7'b0, adc_start}, 8'h00);
    wr(2'd0, 8'h00); wr(2'd3, 8'd20);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R11 adc_start disabled", {7'b0, adc_start}, 8'h00);
    // R12 bit4 stuck in variant without A/D
    wr(2'd0, 8'h00); rd(2'd0, d);
    chk("R12 bit4 after write 0", rdata2 & 8'h10, 8'h10);

    // R2 load suppresses match
    do_reset();
    wr(2'd1, 8'd5);
    @(negedge clk); bus_addr = 2'd3; bus_wdata = 8'd5; bus_wr = 1'b1; step = 1'b1;
    @(negedge clk); bus_wr = 1'b0; step = 1'b0;
    chk("R2 no match on load", {7'b0, irq_cmpa}, 8'h00);
    rd(2'd3, d); chk("R2 load value kept", d, 8'd5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule